// File: doc/BRIEF.md
# MDIO Management Command Controller

This block drives a clause-22 management bus (MDC clock and a tristate MDIO data line) from one 32-bit command and status word. Software writes a single word holding the target PHY address, the register number, the direction, the write data, an enable bit and a busy bit. If busy and enable are both set, the block generates one complete management frame and clears busy when the last bit has gone out. On a read, the 16 bits returned by the PHY replace the low data field of the same word. Software therefore issues a command with one write and then polls the same word until busy reads 0.

MDC is derived from the system clock by a divider with a programmable half period. Elaboration rejects any divider setting under which a 64-bit frame would take longer than a fixed time budget at the stated system clock rate. MDIO changes only while MDC is low. During the turnaround and data phases of a read, the block releases the line and samples it on each rising edge of MDC.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command word reads 0, MDC is low and MDIO is released (output enable 0).
- R2: A write while idle with bit 31 (busy) and bit 30 (enable) both 1 starts a frame, and bit 31 reads 1 from the next cycle on.
- R3: A write while idle with bit 30 = 0 starts no frame. The word is stored with bit 31 reading 0, and MDC stays low.
- R4: A write while bit 31 reads 1 is ignored: the stored fields and the frame in progress are unchanged.
- R5: During a frame, MDC stays low for MDC_HALF cycles after the start and then alternates high and low in halves of MDC_HALF cycles, a period of 2*MDC_HALF. It is low while idle.
- R6: Frame bits 0 to 45, MSB first, are 32 ones, start 01, opcode 10 for a read (bit 27 = 1) or 01 for a write, the PHY address from bits 25:21, and the register number from bits 20:16. MDIO changes only while MDC is low.
- R7: On a write, bits 46 and 47 are the turnaround 10, followed by data bits 15 down to 0. MDIO is driven for all 64 bits.
- R8: On a read, MDIO is released from bit 46 to the end of the frame. The PHY's 16 data bits are sampled on MDC rising edges in bits 48 to 63, and the first sample is data bit 15.
- R9: Bit 31 clears exactly 128*MDC_HALF cycles after the start edge, with MDC low and MDIO released.
- R10: After a frame the word reads back bits 30, 27, 25:21 and 20:16 as written, bits 31, 29, 28 and 26 read 0, and after a write, bits 15:0 still hold the write data.
- R11: After a read frame, bits 15:0 hold the 16-bit value captured from MDIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command and status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable (0 releases the line) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
A wrong divider count or a bit counter that is off by one shows at the ports within the first MDC period: the first rising edge moves away from cycle MDC_HALF, or the busy interval differs from 128*MDC_HALF cycles. A corrupted shift register or a misplaced turnaround appears in the captured bit stream and in the enable pattern of the same frame. A capture error appears in bits 15:0 as soon as busy falls. Sweeping every PHY address in both directions, with a command overwrite attempted in the middle of a frame, exposes field swaps and cases where the busy guard leaks.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
   localparam int BUSY_BIT   = 31;
   localparam int EN_BIT     = 30;
   localparam int RD_BIT     = 27;
   localparam int PHY_LSB    = 21;
   localparam int REG_LSB    = 16;
   localparam int ADDR_W     = 5;
   localparam int DATA_W     = 16;
   localparam int PRE_BITS   = 32;
   localparam int FRAME_BITS = 64;
   localparam int TA_POS     = 46;
   localparam int DATA_POS   = 48;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   typedef struct packed {
      logic              busy;
      logic              en;
      logic              rd;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } cmd_t;

   function automatic logic [FRAME_BITS-1:0] frame_word(
      input logic rd, input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad, input logic [DATA_W-1:0] d);
      return {{PRE_BITS{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
              (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : d)};
   endfunction
endpackage

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
   import mdio_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   input  logic              done,
   input  logic [DATA_W-1:0] cap_data,
   output cmd_t              cmd,
   output logic              start
);
   logic unused_bits;
   assign unused_bits = ^{wdata[29:28], wdata[26]};

   assign start = wr_en && !cmd.busy && wdata[BUSY_BIT] && wdata[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd <= '0;
      end else if (wr_en && !cmd.busy) begin
         cmd.busy  <= wdata[BUSY_BIT] && wdata[EN_BIT];
         cmd.en    <= wdata[EN_BIT];
         cmd.rd    <= wdata[RD_BIT];
         cmd.phy   <= wdata[PHY_LSB +: ADDR_W];
         cmd.regad <= wdata[REG_LSB +: ADDR_W];
         cmd.data  <= wdata[DATA_W-1:0];
      end else if (done) begin
         cmd.busy <= 1'b0;
         if (cmd.rd) cmd.data <= cap_data;
      end
   end
endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int MDC_HALF = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

   logic term;

   generate
      if (MDC_HALF == 1) begin : g_direct
         assign term = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (!run || term)               cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign term = (cnt == CNT_W'(MDC_HALF - 1));
      end
   endgenerate

   assign rise_stb = run && term && !mdc;
   assign fall_stb = run && term && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mdc <= 1'b0;
      else if (!run)    mdc <= 1'b0;
      else if (term)    mdc <= ~mdc;
   end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
   import mdio_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rd,
   input  logic [ADDR_W-1:0] phy,
   input  logic [ADDR_W-1:0] regad,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic              done,
   output logic [DATA_W-1:0] cap_data
);
   logic [FRAME_BITS-1:0] sh;
   logic [IDX_W-1:0]      idx;
   logic                  active;
   logic                  is_rd;
   logic                  last_bit;

   assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
   assign done     = fall_stb && active && last_bit;
   assign mdio_o   = sh[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         idx     <= '0;
         active  <= 1'b0;
         is_rd   <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (start) begin
         sh      <= frame_word(rd, phy, regad, wdata);
         idx     <= '0;
         active  <= 1'b1;
         is_rd   <= rd;
         mdio_oe <= 1'b1;
      end else if (fall_stb && active) begin
         if (last_bit) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
         end else begin
            idx     <= idx + 1'b1;
            sh      <= {sh[FRAME_BITS-2:0], 1'b0};
            mdio_oe <= mdio_oe && !(is_rd && idx == IDX_W'(TA_POS - 1));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cap_data <= '0;
      else if (rise_stb && active && is_rd && idx >= IDX_W'(DATA_POS))
         cap_data <= {cap_data[DATA_W-2:0], mdio_i};
   end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_cmd_pkg::*;
#(
   parameter int CLK_MHZ   = 100,
   parameter int MDC_HALF  = 12,
   parameter int BUDGET_US = 20
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int FRAME_CYC  = 2 * MDC_HALF * FRAME_BITS;
   localparam int BUDGET_CYC = BUDGET_US * CLK_MHZ;

   generate
      if (MDC_HALF < 1) begin : g_bad_half
         $error("MDC_HALF must be at least 1");
      end
      if (FRAME_CYC > BUDGET_CYC) begin : g_bad_budget
         $error("frame of %0d cycles exceeds budget of %0d", FRAME_CYC, BUDGET_CYC);
      end
   endgenerate

   cmd_t              cmd;
   logic              start;
   logic              done;
   logic              rise_stb;
   logic              fall_stb;
   logic [DATA_W-1:0] cap_data;

   mdio_cmd_reg reg_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
      .done(done), .cap_data(cap_data), .cmd(cmd), .start(start)
   );

   mdio_clk_div #(.MDC_HALF(MDC_HALF)) div_i (
      .clk(clk), .rst_n(rst_n), .run(cmd.busy),
      .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
   );

   mdio_frame_shifter shf_i (
      .clk(clk), .rst_n(rst_n), .start(start), .rd(reg_wdata[RD_BIT]),
      .phy(reg_wdata[PHY_LSB +: ADDR_W]), .regad(reg_wdata[REG_LSB +: ADDR_W]),
      .wdata(reg_wdata[DATA_W-1:0]), .rise_stb(rise_stb), .fall_stb(fall_stb),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done),
      .cap_data(cap_data)
   );

   assign reg_rdata = {cmd.busy, cmd.en, 2'b00, cmd.rd, 1'b0,
                       cmd.phy, cmd.regad, cmd.data};
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_en,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe
);
   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !reg_rdata[31] && reg_wdata[31] && reg_wdata[30]) |=> reg_rdata[31]);

   // R3
   no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && !reg_rdata[31] && !reg_wdata[30]) |=> !reg_rdata[31]);

   // R4
   busy_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[31] && reg_wr_en) |=> $stable(reg_rdata[30:16]));

   // R5
   idle_mdc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[31] |-> !mdc);

   // R6
   mdio_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> !mdc);

   // R8
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[31] |-> !mdio_oe);

   // R9
   end_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata[31]) |-> (!mdc && !mdio_oe));
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
module mdio_cmd_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 3;
   localparam int FRAME_CYC  = 128 * HALF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_cmd_ctrl #(.CLK_MHZ(100), .MDC_HALF(HALF), .BUDGET_US(20)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                            input logic [15:0] wd, input logic [15:0] rv, input bit poke);
      logic [63:0] cap = '0;
      logic [63:0] cap_oe = '0;
      logic [63:0] exp_bits;
      logic [63:0] exp_oe;
      logic [31:0] exp_word;
      int busy_cyc = 0;
      int idx = 0;
      int first_rise = 0;
      int last_rise = 0;
      logic prev = 1'b0;
      @(negedge clk);
      reg_wdata = {1'b1, 1'b1, 2'b00, rd, 1'b0, phy, ra, wd};
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      check(reg_rdata[31] == 1'b1, "R2", "busy after start", 64'(reg_rdata[31]), 64'd1);
      while (reg_rdata[31] && busy_cyc < 100000) begin
         busy_cyc++;
         if (mdc && !prev) begin
            if (idx < 64) begin
               cap[63-idx]    = mdio_o;
               cap_oe[63-idx] = mdio_oe;
            end
            if (idx == 0) first_rise = busy_cyc;
            last_rise = busy_cyc;
            idx++;
         end
         prev = mdc;
         mdio_i = (idx >= 48 && idx < 64) ? rv[63-idx] : 1'b1;
         if (poke && busy_cyc == 50) begin
            reg_wdata = 32'hFFFF_FFFF;
            reg_wr_en = 1'b1;
         end else begin
            reg_wr_en = 1'b0;
         end
         @(negedge clk);
      end
      reg_wr_en = 1'b0;
      mdio_i = 1'b1;
      exp_bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
      exp_oe   = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
      check(busy_cyc == FRAME_CYC, "R9", "busy length", 64'(busy_cyc), 64'(FRAME_CYC));
      check(idx == 64, "R5", "MDC rising edges", 64'(idx), 64'd64);
      check(first_rise == HALF + 1, "R5", "first MDC rise", 64'(first_rise), 64'(HALF + 1));
      check(last_rise - first_rise == 63 * 2 * HALF, "R5", "MDC period span",
            64'(last_rise - first_rise), 64'(63 * 2 * HALF));
      check(cap[63:18] == exp_bits[63:18], "R6", "header bits", cap, exp_bits);
      if (!rd) check(cap == exp_bits, "R7", "write frame bits", cap, exp_bits);
      check(cap_oe == exp_oe, rd ? "R8" : "R7", "output enable pattern", cap_oe, exp_oe);
      check(!mdc && !mdio_oe, "R9", "idle after frame", 64'({mdc, mdio_oe}), 64'd0);
      exp_word = {1'b0, 1'b1, 2'b00, rd, 1'b0, phy, ra, (rd ? rv : wd)};
      check(reg_rdata == exp_word, rd ? "R11" : "R10", "readback word",
            64'(reg_rdata), 64'(exp_word));
      if (poke)
         check(reg_rdata[30:16] == exp_word[30:16], "R4", "fields after busy write",
               64'(reg_rdata[30:16]), 64'(exp_word[30:16]));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check(reg_rdata == 32'd0, "R1", "word at reset", 64'(reg_rdata), 64'd0);
      check(!mdc && !mdio_oe, "R1", "bus at reset", 64'({mdc, mdio_oe}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(reg_rdata == 32'd0 && !mdc && !mdio_oe, "R1", "after release",
            64'(reg_rdata), 64'd0);

      // R3: enable clear, busy set
      reg_wdata = {1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 5'd9, 5'd4, 16'h1234};
      reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
      check(reg_rdata == {1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 5'd9, 5'd4, 16'h1234}, "R3",
            "stored without busy", 64'(reg_rdata),
            64'({1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 5'd9, 5'd4, 16'h1234}));
      begin
         bit quiet = 1'b1;
         for (int k = 0; k < 4 * HALF; k++) begin
            if (mdc || mdio_oe || reg_rdata[31]) quiet = 1'b0;
            @(negedge clk);
         end
         check(quiet, "R3", "no frame without enable", 64'(quiet), 64'd1);
      end

      // R6 R7 R8 R10 R11: sweep all PHY addresses both directions
      for (int p = 0; p < 32; p++) begin
         logic [4:0]  ra = 5'((p * 5 + 3) % 32);
         logic [15:0] wd = 16'(p * 16'h0811) ^ 16'hA5C3;
         logic [15:0] rv = 16'(p * 16'h1357) ^ 16'h3C96;
         run_frame(1'b0, 5'(p), ra, wd, 16'h0000, p == 7);
         run_frame(1'b1, 5'(p), ~ra, ~wd, rv, p == 20);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule